// File: doc/BRIEF.md
# Cache Fill Error Capture Registers

This block keeps a record of the first error that a primary cache fill reports, and holds it until software has read it. Each fill error arrives on a one-cycle strobe. With the strobe come a mode select, two per-longword 7-bit check syndromes or two parity-error flags, an instruction-fetch flag, the address of the 32-byte block being filled and the low address bits of the load that caused the fill. The first error loads a 64-bit physical address register, a 14-bit syndrome register and three status flags, and then sets a lock.

Errors that arrive while the lock is held leave the captured contents unchanged. They set a sticky multiple-error flag instead. Software reads the address on a simple read port. That read releases the lock and clears all held state. If a new error arrives in the same cycle as the read, the new error is captured and the lock is set again.

Top module: `fill_err_capture`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the address, the syndrome, all four status flags and `locked`.
- R2: When `err_strobe` is high and the block is unlocked, the next cycle shows `locked` = 1. It also shows `rd_addr[33:5]` = `blk_addr` and exactly one of `stat_edc` (check-code mode, `mode_par` = 0) or `stat_par` (parity mode, `mode_par` = 1).
- R3: In check-code mode the syndrome register holds `syn_hi` in bits 13..7 and `syn_lo` in bits 6..0. A zero syndrome for a longword means that longword had no error.
- R4: In parity mode, syndrome bit 0 equals `par_lo` and bit 7 equals `par_hi`. Bits 13..8 and 6..1 are zero, whatever values `syn_lo` and `syn_hi` carry.
- R5: On a data fill (`ifetch` = 0), address bits 4..2 hold `ld_low`. On an instruction fill (`ifetch` = 1) they are zero and `stat_ifetch` is 1.
- R6: Address bits 63..34 and 1..0 are always zero.
- R7: While `locked` is 1 and `rd_en` is 0, a new `err_strobe` leaves the address, the syndrome and the three event flags unchanged, and sets `stat_multi` in the next cycle.
- R8: While `rd_en` is high, `rd_addr` shows the captured address. If no error arrives in that cycle, the next cycle shows `locked` = 0 and all registers and flags at zero, `stat_multi` included.
- R9: If `rd_en` and `err_strobe` are high in the same cycle, the new error is captured, `locked` stays 1 and `stat_multi` is 0.
- R10: After an unlocking read, the next error is captured in full, as R2 to R5 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_strobe | input | 1 | One-cycle fill error indication |
| mode_par | input | 1 | 0 = check-code mode, 1 = parity mode |
| syn_lo | input | 7 | Syndrome of the lower longword |
| syn_hi | input | 7 | Syndrome of the upper longword |
| par_lo | input | 1 | Parity error on the lower longword |
| par_hi | input | 1 | Parity error on the upper longword |
| ifetch | input | 1 | Fill was for an instruction fetch |
| blk_addr | input | 29 | Physical address bits 33..5 of the block being filled |
| ld_low | input | 3 | Physical address bits 4..2 of the triggering load |
| rd_en | input | 1 | Read of the address register; releases the lock |
| rd_addr | output | 64 | Captured physical address |
| syn_out | output | 14 | Captured syndrome |
| stat_edc | output | 1 | Captured event was a check-code error |
| stat_par | output | 1 | Captured event was a parity error |
| stat_ifetch | output | 1 | Captured event was an instruction fill |
| stat_multi | output | 1 | Further errors arrived while locked |
| locked | output | 1 | Capture registers hold an event |

## Verification
The hardest case to reach from the ports is an unlocking read that lands in the same cycle as a fresh error strobe. In that cycle the release and the new capture compete. The bench first holds the block locked with a stale event and raises `stat_multi` with a second strobe. It then drives `rd_en` and a third error with different data on the same negative edge. It checks that the third event's address and syndrome are the ones held, and that the multiple-error flag has cleared.

// File: rtl/fec_pkg.sv
package fec_pkg;
   typedef enum logic {
      CHK_CODE = 1'b0,
      CHK_PAR  = 1'b1
   } chk_mode_e;

   typedef struct packed {
      logic edc;
      logic par;
      logic ifetch;
   } fec_stat_t;
endpackage

// File: rtl/fec_syn_fmt.sv
module fec_syn_fmt #(
   parameter int SYN_W = 7
) (
   input  logic               mode_par,
   input  logic [SYN_W-1:0]   syn_lo,
   input  logic [SYN_W-1:0]   syn_hi,
   input  logic               par_lo,
   input  logic               par_hi,
   output logic [2*SYN_W-1:0] syn_fmt
);
   localparam int LANES = 2;

   if (SYN_W < 1) begin : g_bad_w
      $error("fec_syn_fmt: SYN_W must be at least 1");
   end

   logic [LANES-1:0][SYN_W-1:0] lane_syn;
   logic [LANES-1:0]            lane_par;

   assign lane_syn[0] = syn_lo;
   assign lane_syn[1] = syn_hi;
   assign lane_par[0] = par_lo;
   assign lane_par[1] = par_hi;

   // one field per longword; parity mode keeps only the field's LSB
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
         if (mode_par == fec_pkg::CHK_PAR)
            syn_fmt[g*SYN_W +: SYN_W] = {{(SYN_W-1){1'b0}}, lane_par[g]};
         else
            syn_fmt[g*SYN_W +: SYN_W] = lane_syn[g];
      end
   end
endmodule

// File: rtl/fec_addr_fmt.sv
module fec_addr_fmt #(
   parameter int PA_W        = 64,
   parameter int PA_HI       = 33,
   parameter int BLK_LSB     = 5,
   parameter int LD_LSB      = 2,
   parameter bit IFETCH_ZERO = 1'b1,
   localparam int BLK_W      = PA_HI - BLK_LSB + 1,
   localparam int LD_W       = BLK_LSB - LD_LSB
) (
   input  logic [BLK_W-1:0] blk_addr,
   input  logic [LD_W-1:0]  ld_low,
   input  logic             ifetch,
   output logic [PA_W-1:0]  addr_fmt
);
   if (PA_HI >= PA_W - 1) begin : g_bad_hi
      $error("fec_addr_fmt: PA_HI must leave zero bits above it");
   end
   if (BLK_LSB <= LD_LSB || LD_LSB < 1) begin : g_bad_lsb
      $error("fec_addr_fmt: need BLK_LSB > LD_LSB >= 1");
   end

   logic [LD_W-1:0] low_sel;

   // variant: drive zero for instruction fills, or pass the load bits
   if (IFETCH_ZERO) begin : g_ifz
      assign low_sel = ifetch ? '0 : ld_low;
   end else begin : g_pass
      assign low_sel = ld_low;
   end

   always_comb begin
      addr_fmt                   = '0;
      addr_fmt[PA_HI:BLK_LSB]    = blk_addr;
      addr_fmt[BLK_LSB-1:LD_LSB] = low_sel;
   end
endmodule

// File: rtl/fec_lock_ctrl.sv
module fec_lock_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic err_strobe,
   input  logic rd_en,
   output logic capture,
   output logic release_q,
   output logic locked_q,
   output logic multi_q
);
   // a read frees the registers in the same cycle, so an error may load
   assign capture   = err_strobe & (~locked_q | rd_en);
   assign release_q = rd_en & ~capture;

   always_ff @(posedge clk) begin
      if (rst) begin
         locked_q <= 1'b0;
         multi_q  <= 1'b0;
      end else if (capture) begin
         locked_q <= 1'b1;
         multi_q  <= 1'b0;
      end else if (release_q) begin
         locked_q <= 1'b0;
         multi_q  <= 1'b0;
      end else if (err_strobe) begin
         multi_q  <= 1'b1;
      end
   end

   a_r8_unlock: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !err_strobe) |=> (!locked_q && !multi_q));
   a_r9_reclaim: assert property (@(posedge clk) disable iff (rst)
      (rd_en && err_strobe) |=> (locked_q && !multi_q));
   a_r7_multi_set: assert property (@(posedge clk) disable iff (rst)
      (locked_q && err_strobe && !rd_en) |=> multi_q);
   a_r2_lock_set: assert property (@(posedge clk) disable iff (rst)
      (!locked_q && err_strobe) |=> locked_q);
endmodule

// File: rtl/fill_err_capture.sv
module fill_err_capture #(
   parameter int PA_W        = 64,
   parameter int PA_HI       = 33,
   parameter int BLK_LSB     = 5,
   parameter int LD_LSB      = 2,
   parameter int SYN_W       = 7,
   parameter bit IFETCH_ZERO = 1'b1,
   localparam int BLK_W      = PA_HI - BLK_LSB + 1,
   localparam int LD_W       = BLK_LSB - LD_LSB,
   localparam int SR_W       = 2 * SYN_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             err_strobe,
   input  logic             mode_par,
   input  logic [SYN_W-1:0] syn_lo,
   input  logic [SYN_W-1:0] syn_hi,
   input  logic             par_lo,
   input  logic             par_hi,
   input  logic             ifetch,
   input  logic [BLK_W-1:0] blk_addr,
   input  logic [LD_W-1:0]  ld_low,
   input  logic             rd_en,
   output logic [PA_W-1:0]  rd_addr,
   output logic [SR_W-1:0]  syn_out,
   output logic             stat_edc,
   output logic             stat_par,
   output logic             stat_ifetch,
   output logic             stat_multi,
   output logic             locked
);
   import fec_pkg::*;

   localparam logic [SR_W-1:0] PAR_KEEP =
      {{(SYN_W-1){1'b0}}, 1'b1, {(SYN_W-1){1'b0}}, 1'b1};

   logic [PA_W-1:0] addr_nx, addr_q;
   logic [SR_W-1:0] syn_nx, syn_q;
   fec_stat_t       stat_nx, stat_q;
   logic            capture, release_q, locked_q, multi_q;

   fec_syn_fmt #(.SYN_W(SYN_W)) u_syn (
      .mode_par (mode_par),
      .syn_lo   (syn_lo),
      .syn_hi   (syn_hi),
      .par_lo   (par_lo),
      .par_hi   (par_hi),
      .syn_fmt  (syn_nx)
   );

   fec_addr_fmt #(
      .PA_W        (PA_W),
      .PA_HI       (PA_HI),
      .BLK_LSB     (BLK_LSB),
      .LD_LSB      (LD_LSB),
      .IFETCH_ZERO (IFETCH_ZERO)
   ) u_addr (
      .blk_addr (blk_addr),
      .ld_low   (ld_low),
      .ifetch   (ifetch),
      .addr_fmt (addr_nx)
   );

   fec_lock_ctrl u_lock (
      .clk        (clk),
      .rst        (rst),
      .err_strobe (err_strobe),
      .rd_en      (rd_en),
      .capture    (capture),
      .release_q  (release_q),
      .locked_q   (locked_q),
      .multi_q    (multi_q)
   );

   always_comb begin
      stat_nx.edc    = (mode_par == CHK_CODE);
      stat_nx.par    = (mode_par == CHK_PAR);
      stat_nx.ifetch = ifetch;
   end

   always_ff @(posedge clk) begin
      if (rst || release_q) begin
         addr_q <= '0;
         syn_q  <= '0;
         stat_q <= '0;
      end else if (capture) begin
         addr_q <= addr_nx;
         syn_q  <= syn_nx;
         stat_q <= stat_nx;
      end
   end

   assign rd_addr     = addr_q;
   assign syn_out     = syn_q;
   assign stat_edc    = stat_q.edc;
   assign stat_par    = stat_q.par;
   assign stat_ifetch = stat_q.ifetch;
   assign stat_multi  = multi_q;
   assign locked      = locked_q;

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (addr_q == '0 && syn_q == '0 && stat_q == '0 && !locked_q && !multi_q));
   a_r6_zero_bits: assert property (@(posedge clk) disable iff (rst)
      (addr_q[PA_W-1:PA_HI+1] == '0 && addr_q[LD_LSB-1:0] == '0));
   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (locked_q && !rd_en) |=> ($stable(addr_q) && $stable(syn_q) && $stable(stat_q)));
   a_r4_par_zero: assert property (@(posedge clk) disable iff (rst)
      stat_q.par |-> ((syn_q & ~PAR_KEEP) == '0));
   a_r2_one_kind: assert property (@(posedge clk) disable iff (rst)
      locked_q |-> (stat_q.edc ^ stat_q.par));
   a_r8_idle_empty: assert property (@(posedge clk) disable iff (rst)
      !locked_q |-> (addr_q == '0 && stat_q == '0));
endmodule

// File: tb/fill_err_capture_bench.sv
module fill_err_capture_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic        err_strobe, mode_par, par_lo, par_hi, ifetch, rd_en;
   logic [6:0]  syn_lo, syn_hi;
   logic [28:0] blk_addr;
   logic [2:0]  ld_low;
   logic [63:0] rd_addr;
   logic [13:0] syn_out;
   logic        stat_edc, stat_par, stat_ifetch, stat_multi, locked;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fill_err_capture u_fill_err_capture (
      .clk(clk), .rst(rst), .err_strobe(err_strobe), .mode_par(mode_par),
      .syn_lo(syn_lo), .syn_hi(syn_hi), .par_lo(par_lo), .par_hi(par_hi),
      .ifetch(ifetch), .blk_addr(blk_addr), .ld_low(ld_low), .rd_en(rd_en),
      .rd_addr(rd_addr), .syn_out(syn_out), .stat_edc(stat_edc),
      .stat_par(stat_par), .stat_ifetch(stat_ifetch), .stat_multi(stat_multi),
      .locked(locked)
   );

   typedef struct packed {
      logic        mode;
      logic        ifet;
      logic [6:0]  slo;
      logic [6:0]  shi;
      logic        plo;
      logic        phi;
      logic [28:0] blk;
      logic [2:0]  low;
      logic [13:0] xsyn;
      logic [33:0] xaddr;
   } row_t;

   localparam int NROW = 6;
   localparam row_t TBL [NROW] = '{
      '{1'b0, 1'b0, 7'h4F, 7'h00, 1'b0, 1'b0, 29'h0000_0001, 3'b101, 14'h004F, 34'h0_0000_0034},
      '{1'b0, 1'b0, 7'h00, 7'h5D, 1'b0, 1'b0, 29'h1FFF_FFFF, 3'b111, 14'h2E80, 34'h3_FFFF_FFFC},
      '{1'b0, 1'b1, 7'h23, 7'h40, 1'b0, 1'b0, 29'h0ABC_DEF0, 3'b110, 14'h2023, 34'h1_579B_DE00},
      '{1'b1, 1'b0, 7'h7F, 7'h55, 1'b1, 1'b0, 29'h0000_0100, 3'b001, 14'h0001, 34'h0_0000_2004},
      '{1'b1, 1'b0, 7'h7F, 7'h7F, 1'b0, 1'b1, 29'h1234_5678, 3'b010, 14'h0080, 34'h2_468A_CF08},
      '{1'b1, 1'b1, 7'h11, 7'h22, 1'b1, 1'b1, 29'h0000_0000, 3'b111, 14'h0081, 34'h0_0000_0000}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      err_strobe = 1'b0; rd_en = 1'b0; mode_par = 1'b0; par_lo = 1'b0;
      par_hi = 1'b0; ifetch = 1'b0; syn_lo = '0; syn_hi = '0;
      blk_addr = '0; ld_low = '0;
   endtask

   task automatic apply_row(input row_t r);
      mode_par = r.mode; ifetch = r.ifet; syn_lo = r.slo; syn_hi = r.shi;
      par_lo = r.plo; par_hi = r.phi; blk_addr = r.blk; ld_low = r.low;
   endtask

   task automatic check_row(input string req, input row_t r);
      check({req, " addr"}, rd_addr, {30'b0, r.xaddr});
      check({req, " syn"}, {50'b0, syn_out}, {50'b0, r.xsyn});
      check({req, " flags"}, {61'b0, stat_edc, stat_par, stat_ifetch},
            {61'b0, ~r.mode, r.mode, r.ifet});
      check({req, " locked"}, {63'b0, locked}, 64'd1);
   endtask

   task automatic check_empty(input string req);
      check({req, " empty"}, {rd_addr, 45'b0, syn_out, stat_edc, stat_par,
            stat_ifetch, stat_multi, locked}, 128'b0 >> 64);
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      check_empty("R1 reset");

      // R2 R3 R4 R5 R6 R8 R10: table walk, capture then unlocking read
      for (int i = 0; i < NROW; i++) begin
         @(negedge clk);
         apply_row(TBL[i]);
         err_strobe = 1'b1;
         @(negedge clk);
         idle_inputs();
         check_row($sformatf("R2/R3/R4/R5/R6/R10 row%0d", i), TBL[i]);
         rd_en = 1'b1;
         #1 check($sformatf("R8 read data row%0d", i), rd_addr, {30'b0, TBL[i].xaddr});
         @(negedge clk);
         rd_en = 1'b0;
         check_empty($sformatf("R8 released row%0d", i));
      end

      // R7: lock holds against a later error, multi flag rises
      @(negedge clk);
      apply_row(TBL[0]); err_strobe = 1'b1;
      @(negedge clk);
      apply_row(TBL[4]); err_strobe = 1'b1;
      @(negedge clk);
      err_strobe = 1'b0;
      check_row("R7 held", TBL[0]);
      check("R7 multi", {63'b0, stat_multi}, 64'd1);
      @(negedge clk);
      check("R7 multi sticky", {63'b0, stat_multi}, 64'd1);

      // R9: read and new error in the same cycle
      apply_row(TBL[2]); err_strobe = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      idle_inputs();
      check_row("R9 recapture", TBL[2]);
      check("R9 multi clear", {63'b0, stat_multi}, 64'd0);

      // R1: reset while locked clears everything
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check_empty("R1 reset locked");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule